// File: doc/BRIEF.md
# Per-Byte Element Tag Generator

This block labels every byte of one destination vector register with a 2-bit tag. The tag tells the write-back and strobe logic downstream how that byte must be handled. A byte can be left alone, written as a masked-off body element, written as an active body element, or treated as tail. The inputs are the starting element (`vstart`), the vector length (`vl`), the element width, the mask-enable bit, the mask register v0 and the position of the current micro-op within its register group. The block only classifies bytes. Producing fill values for tail or masked-off bytes is done elsewhere.

Each byte belongs to one element, and the element's global index is worked out from the uop position and the element width. That index is compared against the prestart, body and tail limits, and it also selects the mask bit in v0. A half-register mode serves widening and narrowing uops, where each uop fills only half of the destination register. In that mode the half that holds no element of the uop is left unchanged. The combinational result can optionally be captured in an output register.

Top module: `ectag_classifier`

## Requirements
- R1: Every byte carries a 2-bit tag coded 0 = unchanged, 1 = body-inactive, 2 = body-active, 3 = tail, and all bytes of one element carry the same tag.
- R2: A byte whose element index is below `vstart` is tagged 0; this takes priority over every other rule except the half-mode rule of R7.
- R3: A byte of an element with index at or beyond `vl` (and not below `vstart`) is tagged 3.
- R4: With `vm` = 0, a body element whose bit in `v0` (bit number = element index) is 0 is tagged 1, and one whose bit is 1 is tagged 2.
- R5: With `vm` = 1 no byte is tagged 1; every body element is tagged 2 whatever `v0` holds.
- R6: With `half` = 0 and element size S = 2^`eew` bytes, byte b belongs to element `uop_idx`*(VLENB/S) + b/S, so later uops in a group address later elements and later `v0` bits.
- R7: With `half` = 1 a uop covers VLENB/(2S) elements. An even `uop_idx` places them in the lower half of the register and an odd one in the upper half, and the other half is tagged 0. The element of byte b in the active half is `uop_idx`*(VLENB/(2S)) + ((b/S) mod (VLENB/(2S))).
- R8: When `vstart` >= `vl`, no byte is tagged 1 or 2.
- R9: `eew` codes 0, 1, 2, 3 select element sizes of 1, 2, 4 and 8 bytes.
- R10: With the output register built in (REG_OUT = 1), `tags` shows the classification of the inputs present at the previous rising clock edge, and it reads all zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| vstart | input | EIDX_W | First element index to be written |
| vl | input | EIDX_W | Vector length in elements |
| eew | input | 2 | Element size code (bytes = 2^eew) |
| half | input | 1 | Uop fills only half of the destination register |
| vm | input | 1 | 1 = unmasked, 0 = use v0 as mask |
| v0 | input | 8*VLENB | Mask register, one bit per element index |
| uop_idx | input | UIDX_W | Position of the uop within its register group |
| tags | output | 2*VLENB | Tag of byte b in bits [2b+1:2b] |

## Verification
The bench uses the defaults VLENB = 16, UIDX_W = 3 and REG_OUT = 1. With these values, element indices run up to 127, so every bit of a 128-bit v0 can be selected, and all four element sizes still leave at least two elements per register, which the half mode needs. The one-cycle latency of the registered output is visible because the model's expectation is delayed by one cycle. The stimulus covers odd and even uop positions, `vstart` above and below `vl`, `vl` at zero and at the 128-element maximum, and the 8-byte element size, where half mode holds a single element.

// File: rtl/ectag_pkg.sv
package ectag_pkg;
  typedef enum logic [1:0] {
    TAG_KEEP  = 2'd0,
    TAG_INACT = 2'd1,
    TAG_ACT   = 2'd2,
    TAG_TAIL  = 2'd3
  } tag_e;
endpackage

// File: rtl/ectag_index.sv
// Maps each byte of the destination register to a global element index
// and flags whether the byte holds an element of this uop at all.
module ectag_index #(
  parameter int VLENB  = 16,
  parameter int EIDX_W = 8,
  parameter int UIDX_W = 3
) (
  input  logic [1:0]                    eew,
  input  logic                          half,
  input  logic [UIDX_W-1:0]             uop_idx,
  output logic [VLENB-1:0][EIDX_W-1:0]  idx,
  output logic [VLENB-1:0]              live
);
  localparam int BW = $clog2(VLENB);

  genvar b;
  generate
    for (b = 0; b < VLENB; b++) begin : g_byte
      logic [BW-1:0]     slot;
      logic [BW-1:0]     lo;
      logic [EIDX_W-1:0] base;
      logic [EIDX_W-1:0] idx_b;
      logic              live_b;
      int                hb;
      int                sh;

      always_comb begin
        slot = BW'(b) >> eew;
        hb   = BW - 1 - int'(eew);
        sh   = BW - int'(eew) - int'(half);
        if (half) begin
          live_b = (slot[hb] == uop_idx[0]);
          lo     = slot & ~(BW'(1) << hb);
        end else begin
          live_b = 1'b1;
          lo     = slot;
        end
        base  = EIDX_W'(uop_idx) << sh;
        idx_b = base + EIDX_W'(lo);
      end

      assign idx[b]  = idx_b;
      assign live[b] = live_b;
    end
  endgenerate
endmodule

// File: rtl/ectag_classify.sv
// Turns element indices into the four-way byte tag.
module ectag_classify
  import ectag_pkg::*;
#(
  parameter int VLENB  = 16,
  parameter int EIDX_W = 8
) (
  input  logic [VLENB-1:0][EIDX_W-1:0]  idx,
  input  logic [VLENB-1:0]              live,
  input  logic [EIDX_W-1:0]             vstart,
  input  logic [EIDX_W-1:0]             vl,
  input  logic                          vm,
  input  logic [(1<<(EIDX_W-1))-1:0]    v0,
  output tag_e [VLENB-1:0]              tags
);
  localparam int MB_W = EIDX_W - 1;

  genvar b;
  generate
    for (b = 0; b < VLENB; b++) begin : g_byte
      tag_e t;
      always_comb begin
        if (!live[b])                           t = TAG_KEEP;
        else if (idx[b] < vstart)               t = TAG_KEEP;
        else if (idx[b] >= vl)                  t = TAG_TAIL;
        else if (!vm && !v0[idx[b][MB_W-1:0]])  t = TAG_INACT;
        else                                    t = TAG_ACT;
      end
      assign tags[b] = t;
    end
  endgenerate
endmodule

// File: rtl/ectag_outreg.sv
// Optional output stage.
module ectag_outreg #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nx;
      always_comb q_nx = d;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nx;
      end
      assign q = q_r;
    end else begin : g_comb
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/ectag_classifier.sv
module ectag_classifier
  import ectag_pkg::*;
#(
  parameter int VLENB   = 16,
  parameter int UIDX_W  = 3,
  parameter bit REG_OUT = 1'b1,
  localparam int VLEN   = 8 * VLENB,
  localparam int EIDX_W = $clog2(VLEN) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EIDX_W-1:0]    vstart,
  input  logic [EIDX_W-1:0]    vl,
  input  logic [1:0]           eew,
  input  logic                 half,
  input  logic                 vm,
  input  logic [VLEN-1:0]      v0,
  input  logic [UIDX_W-1:0]    uop_idx,
  output logic [2*VLENB-1:0]   tags
);
  logic [VLENB-1:0][EIDX_W-1:0] idx;
  logic [VLENB-1:0]             live;
  tag_e [VLENB-1:0]             tag_arr;
  logic [2*VLENB-1:0]           tag_comb;

  ectag_index #(.VLENB(VLENB), .EIDX_W(EIDX_W), .UIDX_W(UIDX_W)) u_index (
    .eew(eew), .half(half), .uop_idx(uop_idx), .idx(idx), .live(live)
  );

  ectag_classify #(.VLENB(VLENB), .EIDX_W(EIDX_W)) u_classify (
    .idx(idx), .live(live), .vstart(vstart), .vl(vl), .vm(vm), .v0(v0),
    .tags(tag_arr)
  );

  genvar b;
  generate
    for (b = 0; b < VLENB; b++) begin : g_flat
      assign tag_comb[2*b +: 2] = tag_arr[b];
    end
  endgenerate

  ectag_outreg #(.W(2*VLENB), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .d(tag_comb), .q(tags)
  );
endmodule

// File: rtl/ectag_checker.sv
module ectag_checker #(
  parameter int VLENB   = 16,
  parameter int EIDX_W  = 8,
  parameter int UIDX_W  = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [EIDX_W-1:0]   vstart,
  input logic [EIDX_W-1:0]   vl,
  input logic [1:0]          eew,
  input logic                half,
  input logic                vm,
  input logic [UIDX_W-1:0]   uop_idx,
  input logic [2*VLENB-1:0]  tag_comb,
  input logic [2*VLENB-1:0]  tags
);
  logic any_body, any_inact, off_half_set, split_elem;

  always_comb begin
    any_body     = 1'b0;
    any_inact    = 1'b0;
    off_half_set = 1'b0;
    split_elem   = 1'b0;
    for (int b = 0; b < VLENB; b++) begin
      logic [1:0] t;
      int bb;
      t  = tag_comb[2*b +: 2];
      bb = (b >> eew) << eew;
      if (t == 2'd1 || t == 2'd2) any_body = 1'b1;
      if (t == 2'd1) any_inact = 1'b1;
      if (t != tag_comb[2*bb +: 2]) split_elem = 1'b1;
      if (half && ((b >= VLENB/2) != uop_idx[0]) && t != 2'd0) off_half_set = 1'b1;
    end
  end

  assert_no_body_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vstart >= vl) |-> !any_body);

  assert_no_inactive_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vm |-> !any_inact);

  assert_off_half_unchanged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> !off_half_set);

  assert_element_uniform_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !split_elem);

  generate
    if (REG_OUT) begin : g_lat
      assert_one_cycle_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tags == $past(tag_comb)));
    end else begin : g_nolat
      assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tags == tag_comb);
    end
  endgenerate
endmodule

bind ectag_classifier ectag_checker #(
  .VLENB(VLENB), .EIDX_W(EIDX_W), .UIDX_W(UIDX_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vstart(vstart), .vl(vl), .eew(eew), .half(half),
  .vm(vm), .uop_idx(uop_idx), .tag_comb(tag_comb), .tags(tags)
);

// File: tb/tb_ectag_classifier.sv
module tb_ectag_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int VLENB  = 16;
  localparam int UIDX_W = 3;
  localparam int VLEN   = 8 * VLENB;
  localparam int EIDX_W = $clog2(VLEN) + 1;

  logic                clk;
  logic                rst_n;
  logic [EIDX_W-1:0]   vstart;
  logic [EIDX_W-1:0]   vl;
  logic [1:0]          eew;
  logic                half;
  logic                vm;
  logic [VLEN-1:0]     v0;
  logic [UIDX_W-1:0]   uop_idx;
  logic [2*VLENB-1:0]  tags;

  int n_vec  = 0;
  int n_fail = 0;
  logic [2*VLENB-1:0] exp_q;

  ectag_classifier #(.VLENB(VLENB), .UIDX_W(UIDX_W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .vstart(vstart), .vl(vl), .eew(eew), .half(half),
    .vm(vm), .v0(v0), .uop_idx(uop_idx), .tags(tags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: walk bytes, derive element number arithmetically.
  function automatic logic [2*VLENB-1:0] model();
    logic [2*VLENB-1:0] r;
    int esz, per, slot, e, t;
    r   = '0;
    esz = 1 << eew;
    per = half ? (VLENB / esz) / 2 : VLENB / esz;
    for (int b = 0; b < VLENB; b++) begin
      slot = b / esz;
      if (half && ((slot / per) != (uop_idx % 2))) t = 0;
      else begin
        e = int'(uop_idx) * per + (slot % per);
        if (e < int'(vstart))  t = 0;
        else if (e >= int'(vl)) t = 3;
        else if (vm == 1'b0 && v0[e] == 1'b0) t = 1;
        else t = 2;
      end
      r[2*b +: 2] = 2'(t);
    end
    return r;
  endfunction

  task automatic apply(input int vs, input int l, input int w, input bit h,
                       input bit m, input logic [VLEN-1:0] mask, input int u,
                       input string req);
    vstart  = EIDX_W'(vs);
    vl      = EIDX_W'(l);
    eew     = 2'(w);
    half    = h;
    vm      = m;
    v0      = mask;
    uop_idx = UIDX_W'(u);
    exp_q   = model();
    @(negedge clk);
    n_vec++;
    if (tags !== exp_q) begin
      n_fail++;
      $display("FAIL %s: tags=%h expected=%h (vstart=%0d vl=%0d eew=%0d half=%0b vm=%0b uop=%0d)",
               req, tags, exp_q, vs, l, w, h, m, u);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_mask();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] alt;
    alt = {(VLEN/2){2'b10}};
    rst_n = 1'b0;
    vstart = '0; vl = EIDX_W'(20); eew = 2'd0; half = 1'b0; vm = 1'b1;
    v0 = '0; uop_idx = '0;
    exp_q = model();
    repeat (3) @(negedge clk);
    n_vec++;
    if (tags !== '0) begin  // R10 reset state
      n_fail++;
      $display("FAIL R10 reset: tags=%h expected=%h", tags, {(2*VLENB){1'b0}});
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (tags !== exp_q) begin  // R10 first registered value
      n_fail++;
      $display("FAIL R10 latency: tags=%h expected=%h", tags, exp_q);
    end

    apply(5, 40, 0, 0, 1, '0, 0, "R2 prestart");
    apply(3, 12, 1, 0, 1, '0, 0, "R2 prestart sew16");
    apply(0, 10, 0, 0, 1, '1, 0, "R3 tail");
    apply(0, 0, 0, 0, 1, '1, 0, "R3 vl zero");
    apply(0, 128, 0, 0, 0, alt, 7, "R3 vl max");
    apply(0, 16, 0, 0, 0, alt, 0, "R4 mask alternating");
    apply(2, 30, 1, 0, 0, rnd_mask(), 1, "R4 mask random");
    apply(0, 16, 0, 0, 1, '0, 0, "R5 vm ignores v0");
    apply(0, 128, 1, 0, 0, rnd_mask(), 3, "R6 uop offset sew16");
    apply(20, 100, 2, 0, 0, rnd_mask(), 6, "R6 uop offset sew32");
    apply(0, 128, 0, 1, 0, rnd_mask(), 0, "R7 half even");
    apply(0, 128, 0, 1, 0, rnd_mask(), 1, "R7 half odd");
    apply(3, 50, 1, 1, 1, '0, 5, "R7 half sew16 odd");
    apply(0, 128, 3, 1, 0, rnd_mask(), 4, "R7 half sew64");
    apply(20, 10, 0, 0, 0, '1, 1, "R8 vstart above vl");
    apply(10, 10, 2, 0, 1, '1, 2, "R8 vstart equal vl");
    apply(0, 9, 2, 0, 0, rnd_mask(), 1, "R9 sew32");
    apply(1, 13, 3, 0, 0, rnd_mask(), 5, "R9 sew64");

    for (int i = 0; i < 400; i++) begin
      apply($urandom_range(0, 128), $urandom_range(0, 128), $urandom_range(0, 3),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rnd_mask(),
            $urandom_range(0, 7), "R1 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule